// File: doc/BRIEF.md
# Asynchronous static memory timing controller

This block runs single accesses to one bank of asynchronous external static memory. The internal side is a simple request port. A requester presents an address, write data and a read/write flag with `req_valid`, and holds them until `req_ready` pulses. On the memory side the block drives a chip select, an output-enable strobe, a write-enable strobe, an address-valid strobe and a shared address/data bus. All of these strobes are active low.

Every access passes through four phases in a fixed order: address setup, address hold, data setup and turnaround. Each phase takes its length from a static configuration input. Reads add two cycles to the data-setup phase and writes do not. In multiplexed mode the address is placed on the shared bus during the two address phases. Outside multiplexed mode the address appears only on the dedicated address output.

An external WAIT input can stretch the data-setup phase. WAIT has a selectable active level, and it first passes through a two-flop synchronizer. It freezes the data-setup countdown only while four or more data-setup cycles remain. A WAIT that arrives later than that leaves the access length unchanged.

Top module: `async_sram_timer`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are 1, `mem_ad_oe` and `req_ready` are 0, and `req_rdata` is 0.
- R2: Address setup lasts `cfg_setup`+1 cycles. When `cfg_mux_en`=1, `mem_adv_n` is 0 for exactly those cycles, and the shared bus is driven with the address through both address phases. When `cfg_mux_en`=0, `mem_adv_n` stays 1 and the shared bus is not driven during the address phases.
- R3: Address hold lasts `cfg_hold`+1 cycles. WAIT never lengthens address setup or address hold.
- R4: Data setup lasts `cfg_strobe`+3 cycles for a read and `cfg_strobe`+1 cycles for a write. `mem_oe_n` (read) or `mem_we_n` (write) is 0 only during data setup. `mem_cs_n` is 0 from the first address-setup cycle through the last data-setup cycle, and `mem_addr` holds the request address throughout.
- R5: Turnaround lasts `cfg_turn`+1 cycles with `mem_cs_n`=1. `req_ready` is 1 for exactly one cycle, which is the last turnaround cycle.
- R6: On a read, `req_rdata` takes the value of `mem_ad_in` in the last data-setup cycle and holds it at all other times.
- R7: On a write, the shared bus is driven with the write data in every data-setup cycle.
- R8: When `cfg_wait_en`=1, WAIT is active when `mem_wait` equals `cfg_wait_hi` (1 means active high, 0 means active low). Each cycle in which the synchronized WAIT is active, while the block is in data setup with at least 4 data-setup cycles remaining, freezes the countdown and adds one cycle. A raw WAIT edge reaches the synchronized value two clock edges later.
- R9: A synchronized WAIT that becomes active when fewer than 4 data-setup cycles remain does not lengthen the access, even if it stays active.
- R10: When `cfg_wait_en`=0, or when `mem_wait` is at the inactive level, data setup has its nominal length.
- R11: When `cfg_bank_en`=0, a pending request starts no access: `mem_cs_n` stays 1 and `req_ready` stays 0. The request starts once `cfg_bank_en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup | input | 4 | Address-setup length minus one |
| cfg_hold | input | 4 | Address-hold length minus one (1 or more) |
| cfg_strobe | input | 8 | Data-setup base length (1 or more) |
| cfg_turn | input | 4 | Turnaround length minus one |
| cfg_wait_en | input | 1 | Honour the WAIT input |
| cfg_wait_hi | input | 1 | WAIT active level (1 = high) |
| cfg_bank_en | input | 1 | Bank enable |
| cfg_mux_en | input | 1 | Address on the shared bus during the address phases |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | W | Request address |
| req_wdata | input | W | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_addr | output | W | Dedicated address output |
| mem_ad_out | output | W | Shared bus output value |
| mem_ad_oe | output | 1 | Shared bus drive enable |
| mem_ad_in | input | W | Shared bus input value |
| mem_wait | input | 1 | Raw WAIT from the memory |

## Verification
The in-RTL assertions check several properties on every cycle. The strobes never overlap, and either strobe implies chip select. The address-valid strobe implies the address is on the bus, and write data is on the bus whenever the write strobe is low. The ready pulse lasts one cycle and is followed by chip select high. The address-phase countdowns always advance, the data-setup countdown freezes exactly when the wait condition holds, and read data changes only at its capture cycle.

Only the bench scenarios can show the phase lengths measured at the pins. The same applies to the exact size of a WAIT stretch relative to the release time, to the boundary at four remaining cycles, to polarity and enable handling, and to bank-enable gating.

// File: rtl/async_sram_timer.sv
module async_sram_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   cfg_setup,
  input  logic [3:0]   cfg_hold,
  input  logic [7:0]   cfg_strobe,
  input  logic [3:0]   cfg_turn,
  input  logic         cfg_wait_en,
  input  logic         cfg_wait_hi,
  input  logic         cfg_bank_en,
  input  logic         cfg_mux_en,
  input  logic         req_valid,
  input  logic         req_write,
  input  logic [W-1:0] req_addr,
  input  logic [W-1:0] req_wdata,
  output logic         req_ready,
  output logic [W-1:0] req_rdata,
  output logic         mem_cs_n,
  output logic         mem_oe_n,
  output logic         mem_we_n,
  output logic         mem_adv_n,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_ad_out,
  output logic         mem_ad_oe,
  input  logic [W-1:0] mem_ad_in,
  input  logic         mem_wait
);
  localparam int CW = 9;
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] RD_EXTRA = CW'(2);
  localparam logic [CW-1:0] WAIT_MIN = CW'(3);

  typedef enum logic [2:0] {P_IDLE, P_SETUP, P_HOLD, P_DATA, P_TURN} phase_t;

  phase_t        state;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [W-1:0]  addr_q, wdata_q;
  logic [1:0]    wsync;
  logic          wait_act, stall, last_rd;

  assign wait_act = cfg_wait_en && (wsync[1] == cfg_wait_hi);
  assign stall    = (state == P_DATA) && wait_act && (cnt >= WAIT_MIN);
  assign last_rd  = (state == P_DATA) && (cnt == '0) && !wr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wsync <= '0;
    else        wsync <= {wsync[0], mem_wait};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= P_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        P_IDLE:
          if (req_valid && cfg_bank_en) begin
            state   <= P_SETUP;
            cnt     <= CW'(cfg_setup);
            wr_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        P_SETUP:
          if (cnt == '0) begin
            state <= P_HOLD;
            cnt   <= CW'(cfg_hold);
          end else cnt <= cnt - ONE;
        P_HOLD:
          if (cnt == '0) begin
            state <= P_DATA;
            cnt   <= wr_q ? CW'(cfg_strobe) : CW'(cfg_strobe) + RD_EXTRA;
          end else cnt <= cnt - ONE;
        P_DATA:
          if (!stall) begin
            if (cnt == '0) begin
              state <= P_TURN;
              cnt   <= CW'(cfg_turn);
            end else cnt <= cnt - ONE;
          end
        P_TURN:
          if (cnt == '0) state <= P_IDLE;
          else           cnt   <= cnt - ONE;
        default: state <= P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       req_rdata <= '0;
    else if (last_rd) req_rdata <= mem_ad_in;

  assign req_ready  = (state == P_TURN) && (cnt == '0);
  assign mem_cs_n   = !(state inside {P_SETUP, P_HOLD, P_DATA});
  assign mem_adv_n  = !(cfg_mux_en && state == P_SETUP);
  assign mem_oe_n   = !(state == P_DATA && !wr_q);
  assign mem_we_n   = !(state == P_DATA && wr_q);
  assign mem_addr   = addr_q;
  assign mem_ad_out = (state == P_DATA) ? wdata_q : addr_q;
  assign mem_ad_oe  = (cfg_mux_en && (state == P_SETUP || state == P_HOLD)) ||
                      (state == P_DATA && wr_q);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> (!mem_cs_n && (mem_oe_n || mem_we_n)));

  // R2
  adv_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_ad_oe && mem_ad_out == mem_addr && !mem_cs_n));

  // R7
  wdata_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_ad_oe && mem_ad_out == wdata_q));

  // R5
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (!req_ready && mem_cs_n));

  // R3
  addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == P_SETUP || state == P_HOLD) && cnt != '0) |=>
      (state == $past(state) && cnt == $past(cnt) - ONE));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == P_DATA && wait_act && cnt >= WAIT_MIN) |=>
      (state == P_DATA && $stable(cnt)));

  // R9
  wait_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == P_DATA && cnt != '0 && (!wait_act || cnt < WAIT_MIN)) |=>
      (state == P_DATA && cnt == $past(cnt) - ONE));

  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_rd |=> $stable(req_rdata));

  // R11
  bank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == P_IDLE && !cfg_bank_en) |=> (mem_cs_n && state == P_IDLE));
endmodule

// File: tb/async_sram_timer_tb.sv
module async_sram_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_setup = '0, cfg_hold = 4'd1, cfg_turn = '0;
  logic [7:0]  cfg_strobe = 8'd1;
  logic        cfg_wait_en = 1'b0, cfg_wait_hi = 1'b1, cfg_bank_en = 1'b1, cfg_mux_en = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        req_ready;
  logic [15:0] req_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_ad_oe;
  logic [15:0] mem_addr, mem_ad_out, mem_ad_in;
  logic        wait_raw = 1'b0;
  logic [15:0] rd_val = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int adv_cnt, aph_cnt, dcnt, tcnt, bus_bad, got_rdy;

  always #5 clk = ~clk;

  assign mem_ad_in = mem_oe_n ? 16'hDEAD : rd_val;

  async_sram_timer #(.W(16)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_strobe(cfg_strobe), .cfg_turn(cfg_turn),
    .cfg_wait_en(cfg_wait_en), .cfg_wait_hi(cfg_wait_hi), .cfg_bank_en(cfg_bank_en),
    .cfg_mux_en(cfg_mux_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_rdata(req_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
    .mem_addr(mem_addr), .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe),
    .mem_ad_in(mem_ad_in), .mem_wait(wait_raw)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int su, input int ho, input int st, input int tu,
                         input bit wen, input bit whi, input bit mux);
    cfg_setup = 4'(su); cfg_hold = 4'(ho); cfg_strobe = 8'(st); cfg_turn = 4'(tu);
    cfg_wait_en = wen; cfg_wait_hi = whi; cfg_mux_en = mux;
  endtask

  // wmode 0: WAIT untouched, 1: toggle at data cycle wk, 2: toggle at wk and wk+1
  task automatic monitor(input logic [15:0] a, input logic [15:0] wd,
                         input int wmode, input int wk);
    adv_cnt = 0; aph_cnt = 0; dcnt = 0; tcnt = 0; bus_bad = 0; got_rdy = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!mem_adv_n) adv_cnt++;
      if (!mem_cs_n && mem_oe_n && mem_we_n) begin
        aph_cnt++;
        if (cfg_mux_en) begin
          if (!(mem_ad_oe && mem_ad_out == a)) bus_bad++;
        end else if (mem_ad_oe) bus_bad++;
      end
      if (!mem_cs_n && mem_addr != a) bus_bad++;
      if (!mem_oe_n || !mem_we_n) begin
        dcnt++;
        if (!mem_we_n && !(mem_ad_oe && mem_ad_out == wd)) bus_bad++;
        if (wmode != 0 && dcnt == wk) wait_raw = ~wait_raw;
        if (wmode == 2 && dcnt == wk + 1) wait_raw = ~wait_raw;
      end
      if (mem_cs_n && dcnt > 0) tcnt++;
      if (req_ready) begin
        got_rdy = 1;
        req_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic do_access(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                           input logic [15:0] rv, input int wmode, input int wk);
    @(negedge clk);
    rd_val = rv; req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    monitor(a, wd, wmode, wk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && mem_adv_n, "R1 strobes idle",
        {mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n}, 15);
    chk(!mem_ad_oe && !req_ready, "R1 bus/ready idle", {mem_ad_oe, req_ready}, 0);
    chk(req_rdata == 16'h0, "R1 rdata", req_rdata, 0);
  endtask

  task automatic t_read_basic;
    set_cfg(2, 1, 3, 1, 0, 1, 1);
    do_access(0, 16'hA5C3, 16'h0, 16'h5A5A, 0, 0);
    chk(got_rdy == 1, "R5 ready seen", got_rdy, 1);
    chk(adv_cnt == 3, "R2 setup/adv", adv_cnt, 3);
    chk(aph_cnt == 5, "R3 hold length", aph_cnt, 5);
    chk(dcnt == 6, "R4 read strobe", dcnt, 6);
    chk(tcnt == 2, "R5 turnaround", tcnt, 2);
    chk(bus_bad == 0, "R2 address on bus", bus_bad, 0);
    chk(req_rdata == 16'h5A5A, "R6 read data", req_rdata, 16'h5A5A);
    @(negedge clk);
    chk(!req_ready && req_rdata == 16'h5A5A, "R6 rdata held", req_rdata, 16'h5A5A);
  endtask

  task automatic t_write_basic;
    set_cfg(0, 3, 5, 0, 0, 1, 1);
    do_access(1, 16'h1234, 16'hBEEF, 16'h0, 0, 0);
    chk(adv_cnt == 1, "R2 setup one", adv_cnt, 1);
    chk(aph_cnt == 5, "R3 hold four", aph_cnt, 5);
    chk(dcnt == 6, "R4 write strobe", dcnt, 6);
    chk(tcnt == 1, "R5 turnaround", tcnt, 1);
    chk(bus_bad == 0, "R7 write data on bus", bus_bad, 0);
    chk(req_rdata == 16'h5A5A, "R6 rdata kept over write", req_rdata, 16'h5A5A);
  endtask

  task automatic t_nonmux;
    set_cfg(1, 2, 1, 2, 0, 1, 0);
    do_access(0, 16'h0F0F, 16'h0, 16'h7777, 0, 0);
    chk(adv_cnt == 0, "R2 no adv in nonmux", adv_cnt, 0);
    chk(bus_bad == 0, "R2 bus idle in nonmux", bus_bad, 0);
    chk(aph_cnt == 5, "R3 address phases", aph_cnt, 5);
    chk(dcnt == 4, "R4 read strobe", dcnt, 4);
    chk(tcnt == 3, "R5 turnaround", tcnt, 3);
    chk(req_rdata == 16'h7777, "R6 read data", req_rdata, 16'h7777);
  endtask

  task automatic t_wait_stretch;
    set_cfg(1, 2, 4, 0, 1, 1, 1);
    wait_raw = 1'b1;
    do_access(0, 16'h2222, 16'h0, 16'h1357, 1, 5);
    chk(aph_cnt == 5, "R3 address phases not stretched", aph_cnt, 5);
    chk(dcnt == 13, "R8 read stretched", dcnt, 13);
    chk(req_rdata == 16'h1357, "R8 read data after stretch", req_rdata, 16'h1357);
    set_cfg(0, 1, 6, 1, 1, 0, 1);
    wait_raw = 1'b0;
    do_access(1, 16'h3333, 16'hC0DE, 16'h0, 1, 3);
    chk(dcnt == 11, "R8 write stretched active-low", dcnt, 11);
    chk(bus_bad == 0, "R7 data during stretch", bus_bad, 0);
    wait_raw = 1'b1;
  endtask

  task automatic t_wait_late;
    set_cfg(1, 1, 4, 0, 1, 1, 1);
    wait_raw = 1'b0;
    do_access(0, 16'h4444, 16'h0, 16'h2468, 2, 3);
    chk(dcnt == 7, "R9 three cycles left", dcnt, 7);
    do_access(0, 16'h4445, 16'h0, 16'h2469, 2, 2);
    chk(dcnt == 8, "R8 four cycles left", dcnt, 8);
    do_access(0, 16'h4446, 16'h0, 16'h246A, 1, 4);
    chk(dcnt == 7, "R9 late and held", dcnt, 7);
    chk(req_rdata == 16'h246A, "R6 read data", req_rdata, 16'h246A);
    wait_raw = 1'b0;
  endtask

  task automatic t_wait_off;
    set_cfg(1, 1, 2, 0, 0, 1, 1);
    wait_raw = 1'b1;
    repeat (3) @(negedge clk);
    do_access(0, 16'h5555, 16'h0, 16'h0, 0, 0);
    chk(dcnt == 5, "R10 disabled", dcnt, 5);
    set_cfg(1, 1, 2, 0, 1, 0, 1);
    do_access(0, 16'h5556, 16'h0, 16'h0, 0, 0);
    chk(dcnt == 5, "R10 inactive level", dcnt, 5);
    wait_raw = 1'b0;
  endtask

  task automatic t_bank_off;
    int seen;
    seen = 0;
    set_cfg(0, 1, 1, 0, 0, 1, 1);
    cfg_bank_en = 1'b0;
    @(negedge clk);
    rd_val = 16'h9999; req_write = 1'b0; req_addr = 16'h6666; req_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!mem_cs_n || req_ready) seen++;
    end
    chk(seen == 0, "R11 bank off idle", seen, 0);
    cfg_bank_en = 1'b1;
    monitor(16'h6666, 16'h0, 0, 0);
    chk(got_rdy == 1 && dcnt == 4, "R11 starts when enabled", dcnt, 4);
    chk(req_rdata == 16'h9999, "R11 read data", req_rdata, 16'h9999);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read_basic();
    t_write_basic();
    t_nonmux();
    t_wait_stretch();
    t_wait_late();
    t_wait_off();
    t_bank_off();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule